// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave that behaves like a 256 x 8 serial EEPROM. It runs on a system clock, samples the open-drain SCL and SDA lines as inputs and pulls SDA low through a single output-enable. After a START it takes in a 7-bit device address with a read/write bit and, for writes, a byte address. It then accepts data bytes. Those bytes go into a page buffer and are copied into the on-chip array only after STOP, at the end of a timed internal write cycle.

During that cycle the block acknowledges nothing, its own address included. A master can therefore poll for completion by sending the device address until it gets an ACK. Reads come in two forms. A current-address read starts at the internal pointer. A selective read first sets the pointer with a dummy write and then issues a repeated START. Sequential reads continue through the whole array and wrap.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe_o = 0) and every one of the 256 bytes reads back as 0xFF.
- R2: The block acknowledges an address byte only when its upper 7 bits equal DEV_ADDR (default 0x50). Bit 0 of that byte is R/W, with 1 meaning read. For any other address the block never pulls SDA low. The block changes SDA only after a falling SCL edge, or to release the line at START or STOP.
- R3: A byte write is START, the device address with R/W = 0, a byte address, one data byte, then STOP. The block ACKs each of the three bytes. STOP starts the internal write, and when that write ends the byte is held at the given address.
- R4: Bits [7:4] of the byte address choose one of 16 pages and bits [3:0] choose the byte within the page. After each data byte the index advances by one and the page stays the same.
- R5: When more than 16 data bytes are sent, the index wraps from 15 to 0 inside the same page. Later bytes overwrite earlier ones, and no other page changes.
- R6: For BUSY_CYCLES clocks after a STOP that ends a write with data, the block ACKs nothing, its own address included. After that it ACKs again and the data is visible.
- R7: A STOP after only the device address and byte address, with no data byte, starts no internal write. The next address byte is acknowledged at once.
- R8: A selective read returns the byte at the address set by the dummy write, MSB first. The sequence is a dummy write of the byte address, a repeated START, then the device address with R/W = 1.
- R9: A current-address read starts one past the last byte accessed. Sequential reads step from 0xFF to 0x00. A master NACK ends the read and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The hardest state to reach from the pins is a page write that has wrapped. It requires the index to pass 15 and come back over bytes already buffered, and the result only becomes visible after the deferred commit. The bench sends 18 bytes starting at index 2, waits out the busy window with acknowledge polling, and reads one byte past the page to show that the neighbouring page is untouched. The busy refusal is reached by polling at once after each STOP. The first poll must fall inside the timer window and get a NACK.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } link_state_e;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {scl_m, scl_s, scl_d} <= 3'b111;
      {sda_m, sda_s, sda_d} <= 3'b111;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - LAST;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DW         = 8,
  localparam int IW        = $clog2(PAGE_BYTES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           we_i,
  input  logic [IW-1:0]                  idx_i,
  input  logic [DW-1:0]                  data_i,
  output logic [PAGE_BYTES-1:0][DW-1:0]  data_o,
  output logic [PAGE_BYTES-1:0]          valid_o
);
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[b]  <= '0;
        valid_o[b] <= 1'b0;
      end else if (clr_i) begin
        valid_o[b] <= 1'b0;
      end else if (we_i && idx_i == IW'(b)) begin
        data_o[b]  <= data_i;
        valid_o[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH      = 256,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int PW        = AW - IW
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  logic [PW-1:0]                  page_i,
  input  logic [PAGE_BYTES-1:0][DW-1:0]  buf_data_i,
  input  logic [PAGE_BYTES-1:0]          buf_valid_i,
  input  logic [AW-1:0]                  raddr_i,
  output logic [DW-1:0]                  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam int PG = a / PAGE_BYTES;
    localparam int IX = a % PAGE_BYTES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[a] <= '1;
      else if (commit_i && page_i == PW'(PG) && buf_valid_i[IX])
        mem[a] <= buf_data_i[IX];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int PW = AW - IW;
  localparam logic [IW-1:0] IDX_ONE = 1;
  localparam logic [AW-1:0] PTR_ONE = 1;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;
  logic [7:0] rdata;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_valid;

  link_state_e state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    shreg_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          oe_q, pend_q, rd_q, mack_q;

  logic byte_done, dev_hit, buf_we, buf_clr, timer_start;

  bus_sampler u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  write_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(timer_start), .busy_o(busy), .done_o(commit)
  );

  page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DW(8)) u_pbuf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .we_i(buf_we),
    .idx_i(ptr_q[IW-1:0]), .data_i(shreg_q),
    .data_o(buf_data), .valid_o(buf_valid)
  );

  eeprom_array #(.DEPTH(MEM_BYTES), .DW(8), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(ptr_q[AW-1:IW]),
    .buf_data_i(buf_data), .buf_valid_i(buf_valid),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  assign byte_done   = scl_fall && (bit_cnt_q == 4'd8);
  assign dev_hit     = (shreg_q[7:1] == DEV_ADDR) && !busy;
  assign buf_clr     = byte_done && (state_q == ST_WADDR) && !start_det && !stop_det;
  assign buf_we      = byte_done && (state_q == ST_WDATA) && !start_det && !stop_det;
  assign timer_start = stop_det && pend_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      pend_q    <= 1'b0;
      rd_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      pend_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                oe_q    <= 1'b1;
                rd_q    <= shreg_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              oe_q    <= 1'b1;
              ptr_q   <= shreg_q[AW-1:0];
              state_q <= ST_WADDR_ACK;
            end else begin
              oe_q    <= 1'b1;
              ptr_q   <= {ptr_q[AW-1:IW], ptr_q[IW-1:0] + IDX_ONE};
              pend_q  <= 1'b1;
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              tx_q      <= rdata;
              oe_q      <= ~rdata[7];
              ptr_q     <= ptr_q + PTR_ONE;
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q      <= rdata;
              oe_q      <= ~rdata[7];
              ptr_q     <= ptr_q + PTR_ONE;
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
  import eeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_fall_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_i,
  input logic          busy_i,
  input logic          pend_i,
  input logic          buf_we_i,
  input link_state_e   state_i,
  input logic [AW-1:0] ptr_i
);
  localparam logic [IW-1:0] STEP = 1;

  // R2
  sda_change_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(sda_oe_i));

  // R6
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (state_i == ST_IDLE || state_i == ST_DEV));

  // R3
  commit_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R7
  addr_only_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !pend_i && !busy_i) |=> !busy_i);

  // R4
  page_index_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |=> (ptr_i[AW-1:IW] == $past(ptr_i[AW-1:IW]) &&
                  ptr_i[IW-1:0] == $past(ptr_i[IW-1:0]) + STEP));
endmodule

bind serial_eeprom_slave eeprom_slave_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .start_i(start_det),
  .stop_i(stop_det), .sda_oe_i(sda_oe_o), .busy_i(busy), .pend_i(pend_q),
  .buf_we_i(buf_we), .state_i(state_q), .ptr_i(ptr_q)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;
  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 8;
  localparam int NV = 6;
  // {byte address, data}
  localparam logic [15:0] VEC [NV] = '{
    {8'h00, 8'hA5}, {8'h3F, 8'h5A}, {8'h80, 8'h01},
    {8'hFF, 8'hC3}, {8'h47, 8'h00}, {8'h10, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rbuf [32];
  logic [7:0] expp [16];

  always #2 clk = ~clk;

  serial_eeprom_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic read_sel(input logic [7:0] addr, input int n);
    logic a;
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(addr, a);
    i2c_start(); send_byte({DEV, 1'b1}, a);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    i2c_stop();
  endtask

  task automatic read_cur(input int n);
    logic a;
    i2c_start(); send_byte({DEV, 1'b1}, a);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
  endtask

  // returns ack of the first poll and how many polls were needed
  task automatic poll_ready(output logic first_ack, output int tries);
    logic a;
    tries = 0;
    first_ack = 1'b0;
    a = 1'b0;
    while (!a && tries < 40) begin
      i2c_start(); send_byte({DEV, 1'b0}, a); i2c_stop();
      if (tries == 0) first_ack = a;
      tries++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic a0, a1, a2, fa;
    int tries;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sda released", sda_oe, 0);
    read_sel(8'h20, 4);
    for (int k = 0; k < 4; k++) chk("R1 erased byte", rbuf[k], 8'hFF);

    // R2 foreign address
    i2c_start(); send_byte({7'h51, 1'b0}, a0); i2c_stop();
    chk("R2 foreign address nack", a0, 0);

    // vector table: byte write, poll, selective read
    for (int v = 0; v < NV; v++) begin
      i2c_start();
      send_byte({DEV, 1'b0}, a0);
      send_byte(VEC[v][15:8], a1);
      send_byte(VEC[v][7:0], a2);
      i2c_stop();
      chk("R3 three acks", {a0, a1, a2}, 3'b111);
      poll_ready(fa, tries);
      chk("R6 busy nack on first poll", fa, 0);
      chk("R6 ack resumes", tries < 40, 1);
      read_sel(VEC[v][15:8], 1);
      chk("R8 readback", rbuf[0], VEC[v][7:0]);
    end

    // R4 / R5 page write of 18 bytes starting at index 2
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h52, a1);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h10 + 8'(k), a2);
      expp[(2 + k) % 16] = 8'h10 + 8'(k);
    end
    i2c_stop();
    poll_ready(fa, tries);
    chk("R6 busy after page write", fa, 0);
    read_sel(8'h50, 17);
    for (int j = 0; j < 16; j++) chk("R4 R5 page content", rbuf[j], expp[j]);
    chk("R5 next page untouched", rbuf[16], 8'hFF);

    // R7 address-only write then immediate address
    i2c_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h30, a1); i2c_stop();
    i2c_start(); send_byte({DEV, 1'b0}, a0); i2c_stop();
    chk("R7 no busy after address-only write", a0, 1);
    read_sel(8'h30, 1);
    chk("R7 byte unchanged", rbuf[0], 8'hFF);

    // R9 current-address read wrapping 0xFF -> 0x00
    read_sel(8'hFE, 1);
    read_cur(3);
    chk("R9 byte at 0xFF", rbuf[0], 8'hC3);
    chk("R9 wrap to 0x00", rbuf[1], 8'hA5);
    chk("R9 byte at 0x01", rbuf[2], 8'hFF);
    wq();
    chk("R9 sda released after master nack", sda_oe, 0);
    i2c_stop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule